// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Encoder

This block gathers a set of internal interrupt request lines into one interrupt line toward a CPU and publishes an 8-bit vector naming the most urgent pending source. Each source owns a pending latch. A one-cycle event pulse sets the latch, and a per-source enable bit decides whether the pending source takes part in vector selection and in the interrupt line.

Software finds the source by reading the vector register. A write of any value to that register acknowledges the named source, and the next pending source then appears. A status-clear path with write-1-to-clear semantics removes chosen latches without going through the vector. Source `i` carries the code `12h + 2*i`. The priority is fixed, so a larger code always wins. With the default 27 sources, the codes run from 12h (lowest priority) to 46h (highest).

Top module: `irq_vector_encoder`

## Requirements
- R1: A one-cycle high on `evt_pulse[i]` sets the pending latch of source `i` at that clock edge. The latch stays set until it is cleared by an acknowledge or by a status clear.
- R2: When source `i` is selected, `vec_o` equals `12h + 2*i`, so bit 0 is always zero and the code lies between 12h and 46h.
- R3: When no enabled source is pending, `vec_o` reads 00h and `irq_o` is low.
- R4: A write strobe on `vec_wr` clears only the source that `vec_o` names at that edge, and `vec_o` shows the next pending source in the following cycle. A write strobe while `vec_o` is 00h has no effect.
- R5: Among enabled pending sources, the highest index (the largest code) is always selected.
- R6: When `src_en[i]` is 0, source `i` is kept out of the vector and out of `irq_o`, but its latch is not cleared. Setting the bit back to 1 makes the source visible again.
- R7: When `sts_wr` is high, each 1 in `sts_clr` clears the matching latch and each 0 leaves its latch unchanged.
- R8: If a pulse on `evt_pulse[i]` arrives in the same cycle as an acknowledge or a status clear of source `i`, the source stays pending.
- R9: `vec_rdata` captures `vec_o` at an edge where `vec_rd` is high and holds its value at every other edge. It resets to 00h.
- R10: `irq_o` is high exactly when at least one source is both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | N_SRC | Per-source event pulses that set the latches |
| src_en | input | N_SRC | Per-source enable mask (1 = take part) |
| sts_wr | input | 1 | Status-clear write strobe |
| sts_clr | input | N_SRC | Write-1-to-clear data for the latches |
| vec_wr | input | 1 | Vector register write strobe (acknowledge) |
| vec_rd | input | 1 | Vector register read strobe |
| vec_o | output | 8 | Live vector of the winning source, or 00h |
| vec_rdata | output | 8 | Vector value sampled on a read |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a set of edges where several things happen in the same cycle. One is an acknowledge that lands while a fresh pulse arrives for the source being acknowledged. Another is a masked source that sits pending underneath a lower-priority source. The stimulus produces these deliberately. It sweeps every ordered pair of sources through set, acknowledge and acknowledge again, and it walks mask patterns over a fully pending set. It then fires a pulse together with the acknowledge or the status clear of the same source. A bench model of the latches predicts `vec_o`, `irq_o` and `vec_rdata` on every cycle.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned VEC_W = 8;
  localparam logic [VEC_W-1:0] VEC_BASE = 8'h12;
  localparam logic [VEC_W-1:0] VEC_IDLE = 8'h00;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N_SRC = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  input  logic             sts_wr_i,
  input  logic [N_SRC-1:0] sts_clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] pend_d;
  logic [N_SRC-1:0] clr_all;
  logic             upd_en;

  always_comb begin
    clr_all = ack_clr_i | (sts_wr_i ? sts_clr_i : '0);
    upd_en  = (|set_i) | (|clr_all);
    pend_d  = (pend_q & ~clr_all) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_q[g]); // R1
    AST_PULSE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[g] && clr_all[g]) |=> pend_q[g]); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all[g] && !set_i[g]) |=> !pend_q[g]); // R7
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC = 27
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             hit_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N_SRC-1:0] win_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [IDX_W-1:0] idx;
  logic             hit;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    win_o = '0;
    if (hit) win_o[idx] = 1'b1;
  end

  assign hit_o = hit;
  assign vec_o = hit ? (VEC_BASE + VEC_W'({idx, 1'b0})) : VEC_IDLE;
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [N_SRC-1:0] win_i,
  output logic [VEC_W-1:0] rdata_o,
  output logic [N_SRC-1:0] ack_o
);
  logic [VEC_W-1:0] rd_q;
  logic [VEC_W-1:0] rd_d;

  always_comb begin
    rd_d  = vec_i;
    ack_o = wr_i ? win_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_q <= VEC_IDLE;
    else if (rd_i) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;

  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rd_q)); // R9
  AST_RD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q[0] == 1'b0); // R2
  AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o)); // R4
endmodule

// File: rtl/irq_vector_encoder.sv
module irq_vector_encoder
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_SRC = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_pulse,
  input  logic [N_SRC-1:0] src_en,
  input  logic             sts_wr,
  input  logic [N_SRC-1:0] sts_clr,
  input  logic             vec_wr,
  input  logic             vec_rd,
  output logic [VEC_W-1:0] vec_o,
  output logic [VEC_W-1:0] vec_rdata,
  output logic             irq_o
);
  localparam logic [VEC_W-1:0] VEC_TOP = VEC_BASE + VEC_W'(2 * (N_SRC - 1));

  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] live;
  logic [N_SRC-1:0] win;
  logic [N_SRC-1:0] ack;
  logic             hit;

  irq_pend_bank #(.N_SRC(N_SRC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (evt_pulse),
    .ack_clr_i (ack),
    .sts_wr_i  (sts_wr),
    .sts_clr_i (sts_clr),
    .pend_o    (pend)
  );

  assign live = pend & src_en;

  irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .req_i (live),
    .hit_o (hit),
    .vec_o (vec_o),
    .win_o (win)
  );

  irq_vec_reg #(.N_SRC(N_SRC)) u_vreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (vec_rd),
    .wr_i    (vec_wr),
    .vec_i   (vec_o),
    .win_i   (win),
    .rdata_o (vec_rdata),
    .ack_o   (ack)
  );

  assign irq_o = hit;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == VEC_IDLE)); // R3
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o >= VEC_BASE && vec_o <= VEC_TOP && !vec_o[0])); // R2
  AST_IRQ_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend & src_en) != '0)); // R10
  AST_MASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_wr && irq_o) |=> ($countones(pend) >= $countones($past(pend)) - 1)); // R6
endmodule

// File: tb/irq_vector_encoder_test.sv
module irq_vector_encoder_test;
  localparam int N = 27;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_pulse = '0;
  logic [N-1:0] src_en = '1;
  logic         sts_wr = 1'b0;
  logic [N-1:0] sts_clr = '0;
  logic         vec_wr = 1'b0;
  logic         vec_rd = 1'b0;
  logic [7:0]   vec_o;
  logic [7:0]   vec_rdata;
  logic         irq_o;

  int tests = 0;
  int fails = 0;
  logic [N-1:0] pm = '0;
  logic [7:0]   rm = 8'h00;

  always #2 clk = ~clk;

  irq_vector_encoder #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .src_en(src_en),
    .sts_wr(sts_wr), .sts_clr(sts_clr), .vec_wr(vec_wr), .vec_rd(vec_rd),
    .vec_o(vec_o), .vec_rdata(vec_rdata), .irq_o(irq_o)
  );

  function automatic logic [7:0] expv(input logic [N-1:0] p, input logic [N-1:0] m);
    logic [7:0] v = 8'h00;
    for (int i = 0; i < N; i++) if (p[i] && m[i]) v = 8'h12 + 8'(2 * i);
    return v;
  endfunction

  task automatic check(input string tag);
    logic [7:0] ev = expv(pm, src_en);
    tests++;
    if (vec_o !== ev || irq_o !== (|(pm & src_en)) || vec_rdata !== rm) begin
      fails++;
      $display("FAIL %s: vec=%h irq=%b rd=%h expected vec=%h irq=%b rd=%h",
               tag, vec_o, irq_o, vec_rdata, ev, |(pm & src_en), rm);
    end
  endtask

  task automatic step(input logic [N-1:0] p, input logic ack, input logic clw,
                      input logic [N-1:0] cd, input logic rd, input string tag);
    logic [N-1:0] ab = '0;
    evt_pulse = p; vec_wr = ack; sts_wr = clw; sts_clr = cd; vec_rd = rd;
    @(posedge clk);
    if (ack) for (int i = 0; i < N; i++) if (pm[i] && src_en[i]) ab = '0 | (N'(1) << i);
    if (rd) rm = expv(pm, src_en);
    pm = (pm & ~ab & ~(clw ? cd : '0)) | p;
    #1;
    evt_pulse = '0; vec_wr = 1'b0; sts_wr = 1'b0; sts_clr = '0; vec_rd = 1'b0;
    check(tag);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R3 R9 reset state");
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R4: acknowledge while idle has no effect
    step('0, 1'b1, 1'b0, '0, 1'b0, "R4 idle ack");
    // R1 R2 R9 R4: every source alone
    for (int i = 0; i < N; i++) begin
      step(N'(1) << i, 1'b0, 1'b0, '0, 1'b0, "R1 R2 single set");
      step('0, 1'b0, 1'b0, '0, 1'b0, "R1 latch holds");
      step('0, 1'b0, 1'b0, '0, 1'b1, "R9 read sample");
      step('0, 1'b1, 1'b0, '0, 1'b0, "R4 ack single");
    end
    // R5 R4: every pair, acknowledged twice
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        step((N'(1) << i) | (N'(1) << j), 1'b0, 1'b0, '0, 1'b0, "R5 pair priority");
        step('0, 1'b1, 1'b0, '0, 1'b0, "R4 next after ack");
        step('0, 1'b1, 1'b0, '0, 1'b0, "R4 second ack");
      end
    // R6 R10: mask walks over a full pending set
    step('1, 1'b0, 1'b0, '0, 1'b0, "R1 all set");
    for (int k = N - 1; k >= 0; k--) begin
      src_en = '1 >> (N - k);
      step('0, 1'b0, 1'b0, '0, 1'b0, "R6 mask hides upper");
    end
    src_en = '0;
    step('0, 1'b1, 1'b0, '0, 1'b1, "R3 R10 all masked");
    src_en = '1;
    step('0, 1'b0, 1'b0, '0, 1'b0, "R6 unmask restores");
    // R9: read strobe absent keeps old sample while vector moves
    step('0, 1'b0, 1'b0, '0, 1'b1, "R9 read top");
    step('0, 1'b1, 1'b0, '0, 1'b0, "R9 hold after ack");
    // R7: zero writes no effect, ones clear
    step('0, 1'b0, 1'b1, '0, 1'b0, "R7 zero clear no effect");
    step('0, 1'b0, 1'b1, 27'h5555555 & '1, 1'b0, "R7 clear pattern");
    step('0, 1'b0, 1'b1, '1, 1'b0, "R7 clear all");
    // R8: pulse with ack of same source, pulse with clear of same source
    step(N'(1) << 9, 1'b0, 1'b0, '0, 1'b0, "R1 set 9");
    step(N'(1) << 9, 1'b1, 1'b0, '0, 1'b0, "R8 pulse beats ack");
    step(N'(1) << 9, 1'b0, 1'b1, N'(1) << 9, 1'b0, "R8 pulse beats clear");
    step('0, 1'b0, 1'b1, N'(1) << 9, 1'b0, "R7 final clear");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule